// File: doc/BRIEF.md
# Interrupt Vector Queue with Host Acknowledge

This block collects interrupt vectors raised by internal events and holds them in a small first-in first-out queue until the host collects them. Each entry carries an 8-bit vector and an address tag that identifies the event's data area. While at least one entry waits in the queue, the block pulls its active-low request line to the host low.

The host collects a vector with an acknowledge read. It lowers its read strobe and the acknowledge strobe while the chip select stays high. The block must also be in remote-terminal mode, and its active-low interrupt enable input must be low. The first clock of such a cycle removes the oldest entry. It copies the vector into a current-vector register and the tag into a current-address register. For the rest of the cycle the vector is presented on both byte lanes of the 16-bit host bus, with a data-valid flag.

An acknowledge while the queue is empty leaves the queue untouched and presents the vector from the previous acknowledge. A push into a full queue is lost and raises a sticky overflow flag.

Top module: `irq_vector_queue`

## Requirements
- R1: `irq_n` is 0 in every cycle in which the queue holds at least one entry, and 1 when it holds none. It follows the entry count as updated at the last clock edge.
- R2: An acknowledge is recognised at a clock edge only when `rd_n`=0, `intack_n`=0, `cs_n`=1, `rt_mode`=1 and `inten_n`=0 all hold together. If any one of these fails, nothing is removed and `bus_valid` stays 0.
- R3: An acknowledge held low for several cycles removes exactly one entry, at its first clock edge. A second entry is removed only after the condition has gone away and returned.
- R4: A removal loads `vec_reg` and `addr_reg` from the oldest entry, so entries leave in the order they arrived. Neither register changes at any other edge.
- R5: In each cycle after an edge at which the acknowledge condition held, `bus_valid`=1 and `bus_data`={`vec_reg`,`vec_reg`}: the vector sits in bits 15:8 and again in bits 7:0. In all other cycles `bus_valid`=0 and `bus_data`=0.
- R6: An acknowledge while the queue is empty changes neither the queue nor `vec_reg` or `addr_reg`. The bus then shows the previously loaded vector on both lanes.
- R7: The queue holds 16 entries. A `push_valid` pulse while it is full, with no removal at the same edge, is dropped and sets `overflow`. `overflow` stays 1 until reset.
- R8: If a push and a removal fall on the same edge, both take effect and the entry count is unchanged. This also holds when the queue is full.
- R9: After reset the queue is empty, `irq_n`=1, `bus_valid`=0, `bus_data`=0, `vec_reg`=0, `addr_reg`=0 and `overflow`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_valid | input | 1 | Queue the entry on `push_vec`/`push_addr` this cycle |
| push_vec | input | 8 | Vector to queue |
| push_addr | input | 12 | Address tag to queue with the vector |
| rd_n | input | 1 | Host read strobe, active low |
| intack_n | input | 1 | Host interrupt acknowledge, active low |
| cs_n | input | 1 | Host chip select, active low (must be high for an acknowledge) |
| rt_mode | input | 1 | High when the device runs in remote-terminal mode |
| inten_n | input | 1 | Interrupt enable, active low |
| irq_n | output | 1 | Interrupt request, active low; only ever pulls low, for an open-drain pad |
| bus_data | output | 16 | Host data: current vector on both byte lanes during an acknowledge |
| bus_valid | output | 1 | `bus_data` holds the vector for the current acknowledge |
| vec_reg | output | 8 | Current-vector register |
| addr_reg | output | 12 | Current-address register |
| overflow | output | 1 | Sticky flag: a push was dropped because the queue was full |

## Verification
The acknowledge is driven in several ways: single-cycle pulses, holds of several cycles, and holds with each of the five qualifying inputs broken in turn. These patterns separate level-triggered from edge-triggered removal and show that every qualifier gates it. Queue traffic ranges from a few distinct vectors to a full sixteen-entry fill plus one extra push. These runs show the arrival order, the dropped push and the sticky flag. Pushes are also placed on the same edge as a removal, with the queue partly filled and with it full, and acknowledges are issued into an empty queue. These cases show that the count is kept and that the registers are held.

// File: rtl/irq_vector_queue.sv
module irq_vector_queue #(
  parameter int VEC_W  = 8,
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push_valid,
  input  logic [VEC_W-1:0]    push_vec,
  input  logic [ADDR_W-1:0]   push_addr,
  input  logic                rd_n,
  input  logic                intack_n,
  input  logic                cs_n,
  input  logic                rt_mode,
  input  logic                inten_n,
  output logic                irq_n,
  output logic [2*VEC_W-1:0]  bus_data,
  output logic                bus_valid,
  output logic [VEC_W-1:0]    vec_reg,
  output logic [ADDR_W-1:0]   addr_reg,
  output logic                overflow
);
  localparam int ENT_W = VEC_W + ADDR_W;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [ENT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             ack_q;

  wire ack_now  = !rd_n && !intack_n && cs_n && rt_mode && !inten_n;
  wire empty    = (count == '0);
  wire full     = (count == CNT_W'(DEPTH));
  wire pop      = ack_now && !ack_q && !empty;
  wire push     = push_valid && (!full || pop);

  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= {push_vec, push_addr};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      ack_q    <= 1'b0;
      vec_reg  <= '0;
      addr_reg <= '0;
      overflow <= 1'b0;
    end else begin
      ack_q <= ack_now;
      if (push) wr_ptr <= next_ptr(wr_ptr);
      if (pop) begin
        rd_ptr              <= next_ptr(rd_ptr);
        {vec_reg, addr_reg} <= mem[rd_ptr];
      end
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
      if (push_valid && !push) overflow <= 1'b1;
    end
  end

  assign irq_n     = empty;
  assign bus_valid = ack_q;
  assign bus_data  = ack_q ? {vec_reg, vec_reg} : '0;
endmodule

// File: rtl/irq_vector_queue_chk.sv
module irq_vector_queue_chk #(
  parameter int VEC_W  = 8,
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 16
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         push_valid,
  input logic                         rd_n,
  input logic                         intack_n,
  input logic                         cs_n,
  input logic                         rt_mode,
  input logic                         inten_n,
  input logic                         irq_n,
  input logic [2*VEC_W-1:0]           bus_data,
  input logic                         bus_valid,
  input logic [VEC_W-1:0]             vec_reg,
  input logic [ADDR_W-1:0]            addr_reg,
  input logic                         overflow,
  input logic [$clog2(DEPTH+1)-1:0]   count
);
  AST_VALID_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> $past(!rd_n && !intack_n && cs_n && rt_mode && !inten_n)); // R2
  AST_LANES_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (bus_data[2*VEC_W-1:VEC_W] == vec_reg && bus_data[VEC_W-1:0] == vec_reg)); // R5
  AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> (bus_data == '0)); // R5
  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> ($stable(vec_reg) && $stable(addr_reg))); // R4
  AST_IRQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_n) |-> bus_valid); // R1
  AST_NO_OVERFLOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(overflow) |-> overflow); // R7
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= ($clog2(DEPTH+1))'(DEPTH)); // R7
  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_valid) && bus_valid |-> $stable(vec_reg)); // R3
endmodule

bind irq_vector_queue irq_vector_queue_chk #(.VEC_W(VEC_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_irq_vector_queue.sv
module tb_irq_vector_queue;
  logic clk = 0, rst_n = 0;
  logic push_valid = 0;
  logic [7:0] push_vec = 0;
  logic [11:0] push_addr = 0;
  logic rd_n = 1, intack_n = 1, cs_n = 1, rt_mode = 1, inten_n = 0;
  logic irq_n, bus_valid, overflow;
  logic [15:0] bus_data;
  logic [7:0] vec_reg;
  logic [11:0] addr_reg;

  int checks = 0, fails = 0, cycles = 0;
  string tag = "R9";
  logic [19:0] q[$];
  logic [7:0] m_vec = 0;
  logic [11:0] m_addr = 0;
  logic m_ovf = 0, m_ackq = 0;

  irq_vector_queue dut (.*);

  always #5 clk = ~clk;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", r, act, exp, cycles);
    end
  endtask

  // reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_vec = 0; m_addr = 0; m_ovf = 0; m_ackq = 0;
    end else begin
      bit cond, pop;
      logic [19:0] e;
      cond = !rd_n && !intack_n && cs_n && rt_mode && !inten_n;
      pop  = cond && !m_ackq && q.size() > 0;
      if (pop) begin e = q.pop_front(); {m_vec, m_addr} = e; end
      if (push_valid) begin
        if (q.size() < 16) q.push_back({push_vec, push_addr});
        else m_ovf = 1;
      end
      m_ackq = cond;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk("R1 irq_n", irq_n, (q.size() == 0));
      chk("R5 bus_valid", bus_valid, m_ackq);
      chk("R5 bus_data", bus_data, m_ackq ? {m_vec, m_vec} : 16'h0);
      chk("R4 vec_reg", vec_reg, m_vec);
      chk("R4 addr_reg", addr_reg, m_addr);
      chk("R7 overflow", overflow, m_ovf);
    end
    if (cycles > 5000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic push1(logic [7:0] v, logic [11:0] a);
    @(negedge clk); push_valid = 1; push_vec = v; push_addr = a;
    @(negedge clk); push_valid = 0;
  endtask

  task automatic ack(int hold);
    @(negedge clk); rd_n = 0; intack_n = 0;
    repeat (hold) @(negedge clk);
    rd_n = 1; intack_n = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9 reset state
    chk("R9 irq_n", irq_n, 1); chk("R9 bus_valid", bus_valid, 0);
    chk("R9 bus_data", bus_data, 0); chk("R9 vec_reg", vec_reg, 0);
    chk("R9 addr_reg", addr_reg, 0); chk("R9 overflow", overflow, 0);

    tag = "R1";
    push1(8'h11, 12'h101); push1(8'h22, 12'h202); push1(8'h33, 12'h303);
    chk("R1 irq asserted", irq_n, 0);

    tag = "R3"; // long hold pops only one
    ack(4);
    chk("R3 one pop vec", vec_reg, 8'h11);
    chk("R3 still pending", irq_n, 0);

    tag = "R2"; // each qualifier broken in turn
    cs_n = 0; ack(2); cs_n = 1;
    rt_mode = 0; ack(2); rt_mode = 1;
    inten_n = 1; ack(2); inten_n = 0;
    @(negedge clk); rd_n = 0; @(negedge clk); rd_n = 1;
    @(negedge clk); intack_n = 0; @(negedge clk); intack_n = 1;
    @(negedge clk);
    chk("R2 no pop when gated", vec_reg, 8'h11);

    tag = "R8"; // push on the same edge as a pop
    @(negedge clk); rd_n = 0; intack_n = 0; push_valid = 1; push_vec = 8'h44; push_addr = 12'h404;
    @(negedge clk); push_valid = 0;
    chk("R8 pop with push", vec_reg, 8'h22);
    rd_n = 1; intack_n = 1;
    ack(1); chk("R4 order", vec_reg, 8'h33);
    ack(1); chk("R4 order last", addr_reg, 12'h404);
    @(negedge clk); chk("R1 released", irq_n, 1);

    tag = "R6"; // empty acknowledge
    ack(2);
    chk("R6 vec kept", vec_reg, 8'h44);
    @(negedge clk); rd_n = 0; intack_n = 0;
    @(negedge clk); chk("R6 bus shows last", bus_data, 16'h4444);
    rd_n = 1; intack_n = 1;
    push1(8'h55, 12'h505); ack(1); chk("R6 pointers intact", vec_reg, 8'h55);

    tag = "R7"; // fill plus one
    for (int i = 0; i < 17; i++) push1(8'h80 + 8'(i), 12'h800 + 12'(i));
    chk("R7 overflow set", overflow, 1);
    tag = "R8"; // full queue push with pop
    @(negedge clk); rd_n = 0; intack_n = 0; push_valid = 1; push_vec = 8'hEE; push_addr = 12'hEEE;
    @(negedge clk); push_valid = 0; rd_n = 1; intack_n = 1;
    chk("R8 full pop", vec_reg, 8'h80);
    tag = "R4";
    for (int i = 1; i < 16; i++) begin
      ack(1);
      chk("R4 drain order", vec_reg, 8'h80 + 8'(i));
    end
    ack(1); chk("R8 tail entry", vec_reg, 8'hEE);
    @(negedge clk);
    chk("R1 empty after drain", irq_n, 1);
    chk("R7 overflow sticky", overflow, 1);
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule